// File: doc/BRIEF.md
# Wormhole Packet Switch with Output Locking

This block is a single-stage switch with P input ports and P output ports that moves packets made of small flow-control units (flits). Every flit carries a two-bit kind code that marks it as a packet opener, a middle flit, a closer, or a packet of one flit. An opening flit names the output it wants. As soon as that output is free, the opener passes through, and the output stays tied to that input until the closing flit has gone out. The flits of two packets therefore never mix on one output. Only a shallow FIFO sits at each input. It holds the flits that must wait while their output is busy, and a whole packet is never stored.

When several openers ask for the same free output in the same cycle, a round-robin arbiter for that output picks one of them. Both sides of the switch use plain valid/ready handshakes with no credits. A packet that is blocked waits in its input FIFO and pushes back on its sender, and no flit is lost. A middle or closing flit that reaches the front of an input with no open connection is malformed. It is discarded and a one-cycle flag is raised. Route computation, virtual channels and deadlock avoidance belong to the surrounding network and are not part of this block.

Top module: `wh_switch`

## Requirements
- R1: A flit is DW+2 bits wide. Its two top bits are the kind: 01 opens a packet, 00 is a middle flit, 10 closes a packet, and 11 is a single-flit packet that opens and closes together. In an opening flit, the low $clog2(P) payload bits give the destination output.
- R2: An opener accepted at an idle input whose requested output is free appears on that output in the cycle after its input handshake.
- R3: From the cycle an output is granted until its closing flit is accepted, the output carries only flits from the granted input, so packets are never interleaved.
- R4: An output is released in the cycle its closing (or single) flit is accepted. An opener that was waiting for that output is presented in the very next cycle.
- R5: Round-robin arbitration runs separately for each output. After reset its priority starts at input 0. After a grant to input i, priority starts at input (i+1) mod P.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_flit is unchanged. A blocked input drops in_ready once its FIFO is full, and no flit is lost.
- R7: A middle or closing flit that reaches the front of an input with no open connection is discarded. It is never forwarded, and err_drop for that input is high for exactly the one cycle after its input handshake.
- R8: Every well-formed flit is delivered exactly once, on the output its packet opener chose, in the order it entered its input.
- R9: After reset, out_valid and err_drop are all low and in_ready is all high.
- R10: With out_ready held high, a granted connection forwards one flit per cycle, so a packet of n flits leaves in n consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | P | Per-input flit valid |
| in_flit | input | P*(DW+2) | Per-input flit, input k in slice k |
| in_ready | output | P | Per-input FIFO has space |
| out_valid | output | P | Per-output flit valid |
| out_flit | output | P*(DW+2) | Per-output flit, output k in slice k |
| out_ready | input | P | Per-output downstream ready |
| err_drop | output | P | Per-input pulse: a stray middle or closing flit was discarded |

## Verification
Corrupt lock state shows up at an output within a cycle or two. An output that is not locked lets another input's opener in before the previous packet's closer. An output that stays locked too long keeps a waiting opener off the bus past the cycle after the closer, so the release timing and the per-output owner check expose it. A wrong arbitration pointer does not show until the next contention on that output, and the order of winners in directed contention tests reveals it. A lost FIFO entry or a wrong pop shows up as a flit that is missing, duplicated or out of order against the per-input expected stream.

// File: rtl/wh_pkg.sv
package wh_pkg;

    typedef enum logic [1:0] {
        FT_BODY = 2'b00,
        FT_HEAD = 2'b01,
        FT_TAIL = 2'b10,
        FT_SOLO = 2'b11
    } flit_kind_e;

    // bit 0 of the kind marks a packet opener, bit 1 a packet closer
    function automatic logic kind_opens(input logic [1:0] kind);
        return kind[0];
    endfunction

    function automatic logic kind_closes(input logic [1:0] kind);
        return kind[1];
    endfunction

endpackage

// File: rtl/wh_in_fifo.sv
module wh_in_fifo #(
    parameter int FW    = 18,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [FW-1:0] push_data,
    output logic          full,
    input  logic          pop,
    output logic          front_valid,
    output logic [FW-1:0] front_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [FW-1:0] slots [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full        = (count == CW'(DEPTH));
    assign front_valid = (count != '0);
    assign front_data  = slots[rd_ptr];
    assign push_ok     = push && !full;
    assign pop_ok      = pop && front_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) slots[wr_ptr] <= push_data;
    end

    // R6: the switch only removes a flit that is actually present
    a_r6_pop_has_data: assert property (@(posedge clk) disable iff (rst)
        pop |-> front_valid)
        else $error("pop on empty input FIFO");

    // R6: occupancy never exceeds the storage
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH))
        else $error("input FIFO overflow");

endmodule

// File: rtl/wh_rr_arb.sv
module wh_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req,
    input  logic                 advance,
    output logic                 found,
    output logic [$clog2(N)-1:0] gnt_idx
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] ptr;

    always_comb begin
        found   = 1'b0;
        gnt_idx = '0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = int'(ptr) + k;
            if (c >= N) c = c - N;
            if (!found && req[c]) begin
                found   = 1'b1;
                gnt_idx = IW'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (advance && found) begin
            ptr <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + IW'(1);
        end
    end

    // R5: the winner is always one of the requesters
    a_r5_grant_requested: assert property (@(posedge clk) disable iff (rst)
        found |-> req[gnt_idx])
        else $error("grant to a non-requesting input");

    // R5: any request produces a winner
    a_r5_no_lost_request: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> found)
        else $error("requests present but no winner");

endmodule

// File: rtl/wh_out_port.sv
module wh_out_port
    import wh_pkg::*;
#(
    parameter int P  = 4,
    parameter int FW = 18
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [P-1:0]              head_req,
    input  logic [P-1:0]              front_valid,
    input  logic [P-1:0][FW-1:0]      front_flit,
    input  logic                      out_ready,
    output logic                      out_valid,
    output logic [FW-1:0]             out_flit,
    output logic                      fire,
    output logic [$clog2(P)-1:0]      conn_idx,
    output logic                      locked,
    output logic [$clog2(P)-1:0]      owner
);
    localparam int PW = $clog2(P);

    logic          arb_found;
    logic [PW-1:0] arb_idx;
    logic          grant_now;
    logic          conn_valid;
    logic          closing;

    wh_rr_arb #(.N(P)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (locked ? '0 : head_req),
        .advance (grant_now),
        .found   (arb_found),
        .gnt_idx (arb_idx)
    );

    // a free output grants and passes the opener through in the same cycle
    assign grant_now  = !locked && arb_found;
    assign conn_valid = locked || arb_found;
    assign conn_idx   = locked ? owner : arb_idx;
    assign out_valid  = conn_valid && front_valid[conn_idx];
    assign out_flit   = front_flit[conn_idx];
    assign fire       = out_valid && out_ready;
    assign closing    = fire && kind_closes(out_flit[FW-1:FW-2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
            owner  <= '0;
        end else if (closing) begin
            locked <= 1'b0;
        end else if (grant_now) begin
            locked <= 1'b1;
            owner  <= arb_idx;
        end
    end

    // R6: an offered flit is held until taken
    a_r6_hold_offer: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_flit)))
        else $error("offered flit withdrawn or changed");

    // R3: a held output keeps its owner until the closer is accepted
    a_r3_keep_owner: assert property (@(posedge clk) disable iff (rst)
        (locked && !closing) |=> (locked && $stable(owner)))
        else $error("output lost its owner mid-packet");

    // R4: acceptance of a closer frees the output
    a_r4_release_on_close: assert property (@(posedge clk) disable iff (rst)
        closing |=> !locked)
        else $error("output not released after closer");

endmodule

// File: rtl/wh_switch.sv
module wh_switch
    import wh_pkg::*;
#(
    parameter int P     = 4,
    parameter int DW    = 16,
    parameter int DEPTH = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [P-1:0]          in_valid,
    input  logic [P*(DW+2)-1:0]   in_flit,
    output logic [P-1:0]          in_ready,
    output logic [P-1:0]          out_valid,
    output logic [P*(DW+2)-1:0]   out_flit,
    input  logic [P-1:0]          out_ready,
    output logic [P-1:0]          err_drop
);
    localparam int FW = DW + 2;
    localparam int PW = $clog2(P);

    logic [P-1:0][FW-1:0] front_flit;
    logic [P-1:0]         front_valid;
    logic [P-1:0]         fifo_full;
    logic [P-1:0]         pop;
    logic [P-1:0]         bound;
    logic [P-1:0]         stray;
    logic [P-1:0]         served;
    logic [P-1:0][P-1:0]  req_to;    // [output][input]
    logic [P-1:0][P-1:0]  lock_of;   // [input][output]

    logic [P-1:0]          port_fire;
    logic [P-1:0]          port_locked;
    logic [P-1:0][PW-1:0]  port_conn;
    logic [P-1:0][PW-1:0]  port_owner;

    // input side: one shallow FIFO per port
    for (genvar i = 0; i < P; i++) begin : g_in
        wh_in_fifo #(.FW(FW), .DEPTH(DEPTH)) u_fifo (
            .clk         (clk),
            .rst         (rst),
            .push        (in_valid[i]),
            .push_data   (in_flit[i*FW +: FW]),
            .full        (fifo_full[i]),
            .pop         (pop[i]),
            .front_valid (front_valid[i]),
            .front_data  (front_flit[i])
        );
        assign in_ready[i] = !fifo_full[i];
    end

    // which inputs currently own an output
    always_comb begin
        for (int i = 0; i < P; i++) begin
            for (int o = 0; o < P; o++) begin
                lock_of[i][o] = port_locked[o] && (port_owner[o] == PW'(i));
            end
            bound[i] = |lock_of[i];
        end
    end

    // opener requests and stray detection at each FIFO front
    always_comb begin
        for (int i = 0; i < P; i++) begin
            logic [1:0] kind;
            kind     = front_flit[i][FW-1:FW-2];
            stray[i] = front_valid[i] && !bound[i] && !kind_opens(kind);
            for (int o = 0; o < P; o++) begin
                req_to[o][i] = front_valid[i] && !bound[i] && kind_opens(kind)
                               && (front_flit[i][PW-1:0] == PW'(o));
            end
        end
    end

    // output side: one lock and arbiter per port
    for (genvar o = 0; o < P; o++) begin : g_out
        wh_out_port #(.P(P), .FW(FW)) u_port (
            .clk         (clk),
            .rst         (rst),
            .head_req    (req_to[o]),
            .front_valid (front_valid),
            .front_flit  (front_flit),
            .out_ready   (out_ready[o]),
            .out_valid   (out_valid[o]),
            .out_flit    (out_flit[o*FW +: FW]),
            .fire        (port_fire[o]),
            .conn_idx    (port_conn[o]),
            .locked      (port_locked[o]),
            .owner       (port_owner[o])
        );
    end

    always_comb begin
        for (int i = 0; i < P; i++) begin
            served[i] = 1'b0;
            for (int o = 0; o < P; o++) begin
                if (port_fire[o] && (port_conn[o] == PW'(i))) served[i] = 1'b1;
            end
        end
    end

    assign pop      = served | stray;
    assign err_drop = stray;

    for (genvar i = 0; i < P; i++) begin : g_chk
        // R3: an input holds at most one output at a time
        a_r3_one_lock_per_input: assert property (@(posedge clk) disable iff (rst)
            $countones(lock_of[i]) <= 1)
            else $error("input holds several outputs");

        // R7: a discarded flit never leaves on any output
        a_r7_stray_not_forwarded: assert property (@(posedge clk) disable iff (rst)
            err_drop[i] |-> !served[i])
            else $error("stray flit forwarded");
    end

endmodule

// File: tb/test_wh_switch.sv
`timescale 1ns/1ps
module test_wh_switch;
    import wh_pkg::*;

    localparam int P     = 4;
    localparam int DW    = 16;
    localparam int FW    = DW + 2;
    localparam int DEPTH = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [P-1:0]      in_valid  = '0;
    logic [P*FW-1:0]   in_flit   = '0;
    logic [P-1:0]      in_ready;
    logic [P-1:0]      out_valid;
    logic [P*FW-1:0]   out_flit;
    logic [P-1:0]      out_ready = '0;
    logic [P-1:0]      err_drop;

    always #2 clk = ~clk;

    wh_switch #(.P(P), .DW(DW), .DEPTH(DEPTH)) i_wh_switch (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
        .out_valid(out_valid), .out_flit(out_flit), .out_ready(out_ready),
        .err_drop(err_drop)
    );

    int total = 0;
    int bad   = 0;

    logic [FW:0]   tx_q  [P][$];
    logic [FW-1:0] exp_f [P][$];
    int            exp_c [P][$];
    int            log_src [P][$];
    int            log_cyc [P][$];
    int            log_lat [P][$];
    int            owner_now [P];
    bit            prev_stall [P];
    logic [FW-1:0] prev_flit [P];
    logic [P-1:0]  acc_in = '0;
    logic [P-1:0]  hold_mask = '0;
    int err_cnt = 0, err_cyc_last = -1, stray_exp = 0, stray_acc_last = -1;
    int cyc = 0, seq = 0, rdy_pct = 100, vld_pct = 100;
    bit run = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic add_pkt(input int src, input int dest, input int len);
        for (int k = 0; k < len; k++) begin
            logic [1:0] kind;
            if (len == 1)          kind = FT_SOLO;
            else if (k == 0)       kind = FT_HEAD;
            else if (k == len - 1) kind = FT_TAIL;
            else                   kind = FT_BODY;
            tx_q[src].push_back({1'b0, kind, 12'(seq), 2'(src), 2'(dest)});
            seq++;
        end
    endtask

    task automatic add_stray(input int src, input logic [1:0] kind);
        tx_q[src].push_back({1'b1, kind, 12'(seq), 2'(src), 2'(seq % P)});
        seq++;
    endtask

    task automatic clear_logs();
        for (int o = 0; o < P; o++) begin
            log_src[o].delete();
            log_cyc[o].delete();
            log_lat[o].delete();
        end
    endtask

    function automatic int rr_pick(input int ptr, input logic [P-1:0] mask);
        for (int k = 0; k < P; k++) begin
            if (mask[(ptr + k) % P]) return (ptr + k) % P;
        end
        return -1;
    endfunction

    function automatic bit all_idle();
        for (int i = 0; i < P; i++) begin
            if (tx_q[i].size() != 0 || exp_f[i].size() != 0) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic wait_idle(input int limit);
        int n;
        n = 0;
        while (!all_idle() && n < limit) begin
            @(posedge clk);
            n++;
        end
        if (n >= limit) check(1'b0, "R8", "drain timeout", n, limit);
        repeat (4) @(posedge clk);
    endtask

    task automatic monitor(input int o, input logic [FW-1:0] f);
        int src;
        logic [1:0] kind;
        int lat;
        src  = int'(f[3:2]);
        kind = f[FW-1:FW-2];
        lat  = -1;
        if (exp_f[src].size() == 0) begin
            check(1'b0, "R8", "unexpected flit", f, 0);
        end else begin
            check(f == exp_f[src][0], "R8", "flit order/content", f, exp_f[src][0]);
            lat = cyc - exp_c[src][0];
            void'(exp_f[src].pop_front());
            void'(exp_c[src].pop_front());
        end
        if (kind_opens(kind)) begin
            check(owner_now[o] == -1, "R3", "opener while output held", owner_now[o], -1);
            check(int'(f[1:0]) == o, "R1", "opener on wrong output", o, f[1:0]);
            owner_now[o] = (kind == FT_SOLO) ? -1 : src;
        end else begin
            check(owner_now[o] == src, "R3", "interleaved flit source", src, owner_now[o]);
            if (kind == FT_TAIL) owner_now[o] = -1;
        end
        log_src[o].push_back(src);
        log_cyc[o].push_back(cyc);
        log_lat[o].push_back(lat);
    endtask

    // cycle engine: drive at the falling edge, sample 1 ns later
    always @(negedge clk) begin
        if (run) begin
            for (int i = 0; i < P; i++) begin
                if (acc_in[i]) void'(tx_q[i].pop_front());
                if (tx_q[i].size() > 0 && ($urandom % 100) < vld_pct) begin
                    in_valid[i] = 1'b1;
                    in_flit[i*FW +: FW] = tx_q[i][0][FW-1:0];
                end else begin
                    in_valid[i] = 1'b0;
                end
            end
            for (int o = 0; o < P; o++) begin
                out_ready[o] = (($urandom % 100) < rdy_pct) && !hold_mask[o];
            end
            #1;
            for (int i = 0; i < P; i++) begin
                acc_in[i] = in_valid[i] && in_ready[i];
                if (acc_in[i]) begin
                    if (tx_q[i][0][FW]) begin
                        stray_exp++;
                        stray_acc_last = cyc;
                    end else begin
                        exp_f[i].push_back(tx_q[i][0][FW-1:0]);
                        exp_c[i].push_back(cyc);
                    end
                end
                if (err_drop[i]) begin
                    err_cnt++;
                    err_cyc_last = cyc;
                end
            end
            for (int o = 0; o < P; o++) begin
                logic [FW-1:0] f;
                f = out_flit[o*FW +: FW];
                if (prev_stall[o]) begin
                    check(out_valid[o] && f == prev_flit[o], "R6", "held offer changed",
                          {out_valid[o], f}, {1'b1, prev_flit[o]});
                end
                if (out_valid[o] && out_ready[o]) monitor(o, f);
                prev_stall[o] = out_valid[o] && !out_ready[o];
                prev_flit[o]  = f;
            end
            cyc++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int e0;
        int ptr0;
        int first;
        int second;
        void'($urandom(32'd20240611));
        for (int o = 0; o < P; o++) begin
            owner_now[o]  = -1;
            prev_stall[o] = 1'b0;
            prev_flit[o]  = '0;
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R9: reset state
        check(out_valid == '0, "R9", "out_valid after reset", out_valid, 0);
        check(err_drop == '0, "R9", "err_drop after reset", err_drop, 0);
        check(in_ready == '1, "R9", "in_ready after reset", in_ready, 4'hf);
        @(posedge clk);
        run = 1'b1;

        // R2: cut-through latency of a single-flit packet
        clear_logs();
        add_pkt(0, 1, 1);
        wait_idle(100);
        check(log_src[1].size() == 1, "R2", "single flit count", log_src[1].size(), 1);
        if (log_lat[1].size() > 0)
            check(log_lat[1][0] == 1, "R2", "cut-through latency", log_lat[1][0], 1);

        // R10: streaming a 5-flit packet
        clear_logs();
        add_pkt(2, 3, 5);
        wait_idle(100);
        check(log_src[3].size() == 5, "R10", "packet length out", log_src[3].size(), 5);
        if (log_cyc[3].size() == 5) begin
            for (int k = 1; k < 5; k++)
                check(log_cyc[3][k] == log_cyc[3][0] + k, "R10", "back-to-back cycle",
                      log_cyc[3][k], log_cyc[3][0] + k);
            check(log_lat[3][0] == 1, "R10", "opener latency", log_lat[3][0], 1);
        end

        // R5: round-robin on output 0, pointer starts at 0
        clear_logs();
        ptr0 = 0;
        @(posedge clk);
        add_pkt(1, 0, 1);
        add_pkt(2, 0, 1);
        wait_idle(100);
        first  = rr_pick(ptr0, 4'b0110);
        second = (first == 1) ? 2 : 1;
        ptr0   = (second + 1) % P;
        check(log_src[0].size() == 2, "R5", "grants on output 0", log_src[0].size(), 2);
        if (log_src[0].size() == 2) begin
            check(log_src[0][0] == first, "R5", "first winner", log_src[0][0], first);
            check(log_src[0][1] == second, "R5", "second winner", log_src[0][1], second);
        end
        clear_logs();
        @(posedge clk);
        add_pkt(0, 0, 1);
        add_pkt(3, 0, 1);
        wait_idle(100);
        first = rr_pick(ptr0, 4'b1001);
        check(log_src[0].size() == 2, "R5", "grants after rotation", log_src[0].size(), 2);
        if (log_src[0].size() == 2)
            check(log_src[0][0] == first, "R5", "rotated winner", log_src[0][0], first);

        // R4: release and next-cycle grant on output 2
        clear_logs();
        @(posedge clk);
        add_pkt(0, 2, 3);
        add_pkt(1, 2, 1);
        wait_idle(100);
        check(log_src[2].size() == 4, "R4", "flits on output 2", log_src[2].size(), 4);
        if (log_src[2].size() == 4) begin
            check(log_src[2][0] == 0 && log_src[2][2] == 0, "R4", "holder packet",
                  log_src[2][2], 0);
            check(log_src[2][3] == 1, "R4", "waiter after release", log_src[2][3], 1);
            check(log_cyc[2][3] == log_cyc[2][2] + 1, "R4", "grant cycle after closer",
                  log_cyc[2][3], log_cyc[2][2] + 1);
        end

        // R6: backpressure on output 1
        clear_logs();
        hold_mask = 4'b0010;
        add_pkt(3, 1, 5);
        repeat (12) @(posedge clk);
        #1;
        check(in_ready[3] == 1'b0, "R6", "in_ready with full FIFO", in_ready[3], 0);
        check(out_valid[1] == 1'b1, "R6", "offer held under stall", out_valid[1], 1);
        check(log_src[1].size() == 0, "R6", "nothing taken under stall", log_src[1].size(), 0);
        hold_mask = '0;
        wait_idle(200);
        check(log_src[1].size() == 5, "R6", "all flits after stall", log_src[1].size(), 5);

        // R7: stray middle flit and stray closer
        clear_logs();
        e0 = err_cnt;
        add_stray(3, FT_BODY);
        wait_idle(100);
        check(err_cnt == e0 + 1, "R7", "stray middle flagged", err_cnt, e0 + 1);
        check(err_cyc_last == stray_acc_last + 1, "R7", "flag cycle",
              err_cyc_last, stray_acc_last + 1);
        for (int o = 0; o < P; o++)
            check(log_src[o].size() == 0, "R7", "stray not forwarded", log_src[o].size(), 0);
        add_pkt(0, 1, 2);
        add_stray(0, FT_TAIL);
        wait_idle(100);
        check(err_cnt == e0 + 2, "R7", "stray closer flagged", err_cnt, e0 + 2);
        check(log_src[1].size() == 2, "R7", "packet before stray intact", log_src[1].size(), 2);

        // R8: random traffic with contention, gaps and backpressure
        rdy_pct = 70;
        vld_pct = 80;
        for (int i = 0; i < P; i++) begin
            for (int n = 0; n < 120; n++) begin
                if (($urandom % 25) == 0) add_stray(i, (($urandom % 2) != 0) ? FT_BODY : FT_TAIL);
                add_pkt(i, int'($urandom % P), 1 + int'($urandom % 5));
            end
        end
        wait_idle(60000);
        check(err_cnt == stray_exp, "R7", "random stray count", err_cnt, stray_exp);
        for (int i = 0; i < P; i++)
            check(exp_f[i].size() == 0, "R8", "undelivered flits", exp_f[i].size(), 0);
        for (int o = 0; o < P; o++)
            check(owner_now[o] == -1, "R3", "output left open", owner_now[o], -1);

        run = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule